// File: doc/BRIEF.md
# Shift-and-Extend Integer Adder with Condition Flags

This block is the integer addition stage of a 64-bit processor datapath. Each operation takes two register operands. The second operand first passes through a modifier, which either shifts it by an immediate amount or widens its low word by sign or zero extension. The block then forms the sum in a single cycle, at either full 64-bit width or 32-bit width. The result leaves the block combinationally in the same cycle.

A four-bit condition state holds negative, zero, carry and overflow, and is kept in a register inside the block. Two per-operation controls decide its use:
- One control adds the held carry into the sum. This is what chains multi-word additions.
- The other control lets the operation replace the held flags with flags derived from its own result.

A valid strobe qualifies every operation. Operations without the flag control, and idle cycles, leave the flags untouched.

Top module: `shadd_unit`

## Requirements
- R1: While rst_n is low the flag output is 0000. The bit order of flags_o is {N,Z,C,V}, with N at bit 3 and V at bit 0.
- R2: With wide_i=1, result_o equals op_a_i plus the modified operand plus the carry-in, modulo 2^64.
- R3: flags_o keeps its value across any cycle that lacks both valid_i=1 and set_flags_i=1.
- R4: For a valid 64-bit operation with set_flags_i=1, the flags after the next rising edge are as follows:
  - N is result bit 63.
  - Z is 1 when the result is all zero.
  - C is the carry out of bit 63.
  - V is 1 when both addends share a sign that differs from the sign of the result.
- R5: With wide_i=0, result_o[31:0] is the low-word sum and result_o[63:32] is zero.
- R6: For a valid 32-bit operation with set_flags_i=1, the flags follow the rules of R4 applied to bit 31, the low 32 bits and the carry out of bit 31.
- R7: With mod_sel_i=00 (and also for the reserved code 11), operand 2 is shifted by shift_amt_i. The shift kind is selected by shift_kind_i:
  - 00: logical left.
  - 01: logical right.
  - 10: arithmetic right.
  - 11: operand passed unshifted.

  In 32-bit mode only the low 5 bits of shift_amt_i are used, and the shift acts on the low word, with arithmetic fill taken from bit 31.
- R8: mod_sel_i=01 sign-extends op_b_i[31:0] to 64 bits, and mod_sel_i=10 zero-extends it. The shift controls are ignored in both cases.
- R9: With use_carry_i=1 the held C flag is added as carry-in. With use_carry_i=0 the carry-in is zero.
- R10: A flag-setting 64-bit add of the low halves, followed by a carry-using add of the high halves, yields the correct 128-bit sum.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| valid_i | input | 1 | Qualifies the operation in this cycle |
| wide_i | input | 1 | 1 selects a 64-bit operation, 0 selects a 32-bit operation |
| op_a_i | input | 64 | Operand 1 |
| op_b_i | input | 64 | Operand 2, before modification |
| mod_sel_i | input | 2 | Modifier: 00 shift, 01 sign-extend word, 10 zero-extend word, 11 shift |
| shift_kind_i | input | 2 | Shift kind: 00 LSL, 01 LSR, 10 ASR, 11 none |
| shift_amt_i | input | 6 | Immediate shift amount |
| use_carry_i | input | 1 | Add the held carry flag |
| set_flags_i | input | 1 | Update the flags from this result |
| result_o | output | 64 | Sum (combinational) |
| flags_o | output | 4 | Held flags {N,Z,C,V} |

## Verification
The result is combinational, so a fault in the modifier or in the sum shows on result_o in the same cycle as the operation. A corrupted flag register is different: it is visible on flags_o one edge after the operation, and it spreads into later results only when a following operation uses the carry. The bench therefore checks both ports after every operation. It also runs carry-using chains, so that a wrong held C shows up at once in the high-half sum rather than staying hidden until some later flag read.

// File: rtl/shadd_pkg.sv
`timescale 1ns/1ps
package shadd_pkg;
    typedef enum logic [1:0] {
        MOD_SHIFT = 2'b00,
        MOD_SXTW  = 2'b01,
        MOD_UXTW  = 2'b10,
        MOD_RSVD  = 2'b11
    } opmod_e;

    typedef enum logic [1:0] {
        SH_LSL  = 2'b00,
        SH_LSR  = 2'b01,
        SH_ASR  = 2'b10,
        SH_NONE = 2'b11
    } shkind_e;

    typedef struct packed {
        logic n;
        logic z;
        logic c;
        logic v;
    } nzcv_t;
endpackage

// File: rtl/shadd_opmod.sv
`timescale 1ns/1ps
module shadd_opmod
    import shadd_pkg::*;
#(
    parameter int DATA_W = 64
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wide_i,
    input  logic [DATA_W-1:0]         opnd_i,
    input  opmod_e                    mod_i,
    input  shkind_e                   kind_i,
    input  logic [$clog2(DATA_W)-1:0] amt_i,
    output logic [DATA_W-1:0]         opnd_o
);
    localparam int HALF_W = DATA_W / 2;
    localparam int SH_W   = $clog2(DATA_W);

    logic [HALF_W-1:0] lo_d;
    logic [HALF_W-1:0] lo_sh_d;
    logic [DATA_W-1:0] full_sh_d;
    logic [SH_W-2:0]   amt_lo_d;

    always_comb begin
        lo_d     = opnd_i[HALF_W-1:0];
        amt_lo_d = amt_i[SH_W-2:0];
        unique case (kind_i)
            SH_LSL: begin
                full_sh_d = opnd_i << amt_i;
                lo_sh_d   = lo_d << amt_lo_d;
            end
            SH_LSR: begin
                full_sh_d = opnd_i >> amt_i;
                lo_sh_d   = lo_d >> amt_lo_d;
            end
            SH_ASR: begin
                full_sh_d = $unsigned($signed(opnd_i) >>> amt_i);
                lo_sh_d   = $unsigned($signed(lo_d) >>> amt_lo_d);
            end
            default: begin
                full_sh_d = opnd_i;
                lo_sh_d   = lo_d;
            end
        endcase

        unique case (mod_i)
            MOD_SXTW: opnd_o = wide_i ? {{HALF_W{lo_d[HALF_W-1]}}, lo_d}
                                      : {{HALF_W{1'b0}}, lo_d};
            MOD_UXTW: opnd_o = {{HALF_W{1'b0}}, lo_d};
            default:  opnd_o = wide_i ? full_sh_d : {{HALF_W{1'b0}}, lo_sh_d};
        endcase
    end

    // R7: arithmetic right shift in 64-bit mode preserves the operand sign
    a_r7_asr_sign: assert property (@(posedge clk) disable iff (!rst_n)
        (wide_i && (mod_i == MOD_SHIFT) && (kind_i == SH_ASR))
            |-> (opnd_o[DATA_W-1] == opnd_i[DATA_W-1]));

    // R8: extension ignores the shift controls; low word is passed unchanged
    a_r8_ext_low: assert property (@(posedge clk) disable iff (!rst_n)
        ((mod_i == MOD_SXTW) || (mod_i == MOD_UXTW))
            |-> (opnd_o[HALF_W-1:0] == opnd_i[HALF_W-1:0]));
endmodule

// File: rtl/shadd_core.sv
`timescale 1ns/1ps
module shadd_core
    import shadd_pkg::*;
#(
    parameter int DATA_W = 64
) (
    input  logic              wide_i,
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] b_i,
    input  logic              cin_i,
    output logic [DATA_W-1:0] sum_o,
    output nzcv_t             flags_o
);
    localparam int HALF_W = DATA_W / 2;

    logic [DATA_W:0] full_d;
    logic [HALF_W:0] half_d;

    always_comb begin
        full_d = {1'b0, a_i} + {1'b0, b_i} + {{DATA_W{1'b0}}, cin_i};
        half_d = {1'b0, a_i[HALF_W-1:0]} + {1'b0, b_i[HALF_W-1:0]}
               + {{HALF_W{1'b0}}, cin_i};
        if (wide_i) begin
            sum_o     = full_d[DATA_W-1:0];
            flags_o.n = full_d[DATA_W-1];
            flags_o.z = (full_d[DATA_W-1:0] == '0);
            flags_o.c = full_d[DATA_W];
            flags_o.v = (a_i[DATA_W-1] == b_i[DATA_W-1])
                     && (full_d[DATA_W-1] != a_i[DATA_W-1]);
        end else begin
            sum_o     = {{HALF_W{1'b0}}, half_d[HALF_W-1:0]};
            flags_o.n = half_d[HALF_W-1];
            flags_o.z = (half_d[HALF_W-1:0] == '0);
            flags_o.c = half_d[HALF_W];
            flags_o.v = (a_i[HALF_W-1] == b_i[HALF_W-1])
                     && (half_d[HALF_W-1] != a_i[HALF_W-1]);
        end
    end
endmodule

// File: rtl/shadd_unit.sv
`timescale 1ns/1ps
module shadd_unit
    import shadd_pkg::*;
#(
    parameter int DATA_W = 64
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      valid_i,
    input  logic                      wide_i,
    input  logic [DATA_W-1:0]         op_a_i,
    input  logic [DATA_W-1:0]         op_b_i,
    input  logic [1:0]                mod_sel_i,
    input  logic [1:0]                shift_kind_i,
    input  logic [$clog2(DATA_W)-1:0] shift_amt_i,
    input  logic                      use_carry_i,
    input  logic                      set_flags_i,
    output logic [DATA_W-1:0]         result_o,
    output logic [3:0]                flags_o
);
    localparam int HALF_W = DATA_W / 2;

    typedef struct packed {
        nzcv_t flags;
    } state_t;

    state_t            st_d, st_q;
    logic [DATA_W-1:0] opnd_b;
    nzcv_t             new_flags;
    logic              cin;

    assign cin = use_carry_i & st_q.flags.c;

    shadd_opmod #(.DATA_W(DATA_W)) u_opmod (
        .clk    (clk),
        .rst_n  (rst_n),
        .wide_i (wide_i),
        .opnd_i (op_b_i),
        .mod_i  (opmod_e'(mod_sel_i)),
        .kind_i (shkind_e'(shift_kind_i)),
        .amt_i  (shift_amt_i),
        .opnd_o (opnd_b)
    );

    shadd_core #(.DATA_W(DATA_W)) u_core (
        .wide_i  (wide_i),
        .a_i     (op_a_i),
        .b_i     (opnd_b),
        .cin_i   (cin),
        .sum_o   (result_o),
        .flags_o (new_flags)
    );

    always_comb begin
        st_d = st_q;
        if (valid_i && set_flags_i) begin
            st_d.flags = new_flags;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign flags_o = st_q.flags;

    // R1: flags leave reset cleared
    a_r1_reset_clear: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (flags_o == 4'b0000));

    // R3: flags held without a valid flag-setting operation
    a_r3_flags_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(valid_i && set_flags_i) |=> $stable(flags_o));

    // R5: 32-bit mode clears the upper result half
    a_r5_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !wide_i |-> (result_o[DATA_W-1:HALF_W] == '0));

    // R4: Z flag reflects the 64-bit result of a flag-setting operation
    a_r4_zero_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && set_flags_i && wide_i) |=> (flags_o[2] == ($past(result_o) == '0)));

    // R6: N flag taken from bit 31 in 32-bit mode
    a_r6_narrow_neg: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && set_flags_i && !wide_i) |=> (flags_o[3] == $past(result_o[HALF_W-1])));
endmodule

// File: tb/shadd_unit_tb.sv
`timescale 1ns/1ps
module shadd_unit_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        valid_i = 1'b0;
    logic        wide_i = 1'b1;
    logic [63:0] op_a_i = '0;
    logic [63:0] op_b_i = '0;
    logic [1:0]  mod_sel_i = '0;
    logic [1:0]  shift_kind_i = '0;
    logic [5:0]  shift_amt_i = '0;
    logic        use_carry_i = 1'b0;
    logic        set_flags_i = 1'b0;
    logic [63:0] result_o;
    logic [3:0]  flags_o;

    int   n_cmp = 0;
    int   n_bad = 0;
    bit   done = 1'b0;
    logic [3:0] exp_flags = 4'b0000;

    always #2.5 clk = ~clk;

    shadd_unit u_dut (
        .clk(clk), .rst_n(rst_n), .valid_i(valid_i), .wide_i(wide_i),
        .op_a_i(op_a_i), .op_b_i(op_b_i), .mod_sel_i(mod_sel_i),
        .shift_kind_i(shift_kind_i), .shift_amt_i(shift_amt_i),
        .use_carry_i(use_carry_i), .set_flags_i(set_flags_i),
        .result_o(result_o), .flags_o(flags_o)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [63:0] model_b(input logic [63:0] b, input logic w,
                                            input logic [1:0] m, input logic [1:0] k,
                                            input logic [5:0] s);
        logic [31:0] lo;
        lo = b[31:0];
        if (m == 2'b01) return w ? {{32{lo[31]}}, lo} : {32'h0, lo};
        if (m == 2'b10) return {32'h0, lo};
        if (w) begin
            case (k)
                2'b00:   return b << s;
                2'b01:   return b >> s;
                2'b10:   return $unsigned($signed(b) >>> s);
                default: return b;
            endcase
        end else begin
            case (k)
                2'b00:   return {32'h0, lo << s[4:0]};
                2'b01:   return {32'h0, lo >> s[4:0]};
                2'b10:   return {32'h0, $unsigned($signed(lo) >>> s[4:0])};
                default: return {32'h0, lo};
            endcase
        end
    endfunction

    function automatic logic [67:0] model_sum(input logic [63:0] a, input logic [63:0] b,
                                              input logic w, input logic ci);
        logic [64:0] f;
        logic [32:0] h;
        logic [3:0]  fl;
        f = {1'b0, a} + {1'b0, b} + 65'(ci);
        h = {1'b0, a[31:0]} + {1'b0, b[31:0]} + 33'(ci);
        if (w) begin
            fl = {f[63], f[63:0] == 64'h0, f[64], (a[63] == b[63]) && (f[63] != a[63])};
            return {fl, f[63:0]};
        end
        fl = {h[31], h[31:0] == 32'h0, h[32], (a[31] == b[31]) && (h[31] != a[31])};
        return {fl, 32'h0, h[31:0]};
    endfunction

    // drive at negedge, check result, clock, check flags
    task automatic run_op(input string tag, input logic v, input logic w,
                          input logic [63:0] a, input logic [63:0] b,
                          input logic [1:0] m, input logic [1:0] k,
                          input logic [5:0] s, input logic uc, input logic sf);
        logic [67:0] r;
        @(negedge clk);
        valid_i = v; wide_i = w; op_a_i = a; op_b_i = b; mod_sel_i = m;
        shift_kind_i = k; shift_amt_i = s; use_carry_i = uc; set_flags_i = sf;
        r = model_sum(a, model_b(b, w, m, k, s), w, uc & exp_flags[1]);
        #1;
        chk({tag, " result"}, result_o, r[63:0]);
        if (v && sf) exp_flags = r[67:64];
        @(posedge clk);
        #1;
        chk({tag, " flags"}, {60'h0, flags_o}, {60'h0, exp_flags});
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        logic [63:0] lo_sum;
        void'($urandom(32'd1234));
        repeat (3) @(posedge clk);
        #1;
        chk("R1 reset flags", {60'h0, flags_o}, 64'h0);
        @(negedge clk);
        rst_n = 1'b1;

        // R2 / R4: carry out and zero
        run_op("R4 carry-zero", 1, 1, 64'hFFFF_FFFF_FFFF_FFFF, 64'h1, 0, 0, 0, 0, 1);
        // R9: held carry added
        run_op("R9 carry-in", 1, 1, 64'h10, 64'h20, 0, 0, 0, 1, 0);
        // R3: non-flag op keeps flags
        run_op("R3 keep", 1, 1, 64'h7FFF_FFFF_FFFF_FFFF, 64'h1, 0, 0, 0, 0, 0);
        // R3: invalid flag-setting cycle keeps flags
        run_op("R3 invalid", 0, 1, 64'h1, 64'h1, 0, 0, 0, 0, 1);
        // R4: signed overflow and negative
        run_op("R4 overflow", 1, 1, 64'h7FFF_FFFF_FFFF_FFFF, 64'h1, 0, 0, 0, 0, 1);
        // R5 / R6: 32-bit wrap, upper half cleared
        run_op("R6 narrow carry", 1, 0, 64'hDEAD_BEEF_FFFF_FFFF, 64'h1234_5678_0000_0001, 0, 0, 0, 0, 1);
        run_op("R6 narrow ovf", 1, 0, 64'h0000_0000_7FFF_FFFF, 64'h1, 0, 0, 0, 0, 1);
        run_op("R5 narrow", 1, 0, 64'hFFFF_FFFF_0000_0005, 64'hFFFF_FFFF_0000_0003, 0, 0, 0, 0, 0);
        // R7: shifts
        run_op("R7 lsl", 1, 1, 64'h1, 64'h3, 0, 0, 6'd2, 0, 1);
        run_op("R7 lsr", 1, 1, 64'h0, 64'h8000_0000_0000_0000, 0, 1, 6'd63, 0, 1);
        run_op("R7 asr", 1, 1, 64'h0, 64'h8000_0000_0000_0000, 0, 2, 6'd4, 0, 1);
        run_op("R7 asr narrow amt", 1, 0, 64'h0, 64'h0000_0000_8000_0000, 0, 2, 6'd33, 0, 1);
        run_op("R7 none", 1, 1, 64'h5, 64'h9, 0, 3, 6'd7, 0, 1);
        // R8: extensions, shift controls ignored
        run_op("R8 sxtw", 1, 1, 64'h100, 64'hAAAA_AAAA_FFFF_FFFE, 1, 0, 6'd5, 0, 1);
        run_op("R8 uxtw", 1, 1, 64'h100, 64'hAAAA_AAAA_FFFF_FFFE, 2, 1, 6'd9, 0, 1);
        // R10: 128-bit chain
        run_op("R10 low", 1, 1, 64'hFFFF_FFFF_0000_0001, 64'h0000_0001_FFFF_FFFF, 0, 0, 0, 0, 1);
        lo_sum = result_o;
        run_op("R10 high", 1, 1, 64'h1, 64'h2, 0, 0, 0, 1, 0);
        chk("R10 128-bit", {result_o[31:0], lo_sum[63:32]}, {32'h4, 32'h1});

        // random mix covering R2 R3 R4 R5 R6 R7 R8 R9
        for (int i = 0; i < 600; i++) begin
            logic [63:0] a, b;
            a = {$urandom, $urandom};
            b = {$urandom, $urandom};
            if (i % 7 == 0) b = ~a;
            run_op("R2 random", ($urandom % 8) != 0, $urandom % 2, a, b,
                   2'($urandom), 2'($urandom), 6'($urandom), 1'($urandom), 1'($urandom));
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule